// File: doc/BRIEF.md
# Vertex Attribute Fetch Formatter

This block prepares the input registers of a vertex program for one vertex. It is started with a vertex index and a descriptor count. It first writes the vertex index into component x of register 0. It then works through the attribute descriptors in list order.

For each descriptor it looks up the buffer that the descriptor names and matches the descriptor's semantic against a 32-entry semantic table to pick a destination register. It then reads two, three or four 32-bit words from memory, one outstanding read at a time. The words can be byte-reversed, and each output component is then picked or replaced by a constant according to a per-component select. The 128-bit result goes out on a register write port.

Descriptors, buffer settings and the semantic table come from the surrounding logic through combinational lookup ports. When the list is finished the block pulses a done output.

Top module: `vtx_attr_fetch`

## Requirements
- R1: After a start, the first register write goes to register 0 with mask 0001 and carries the vertex index in bits 31:0. It comes before any attribute write.
- R2: Word k of an attribute is read from address base + index * stride + 4k, in increasing k. The stride is bits 26:11 of the buffer layout word. A request holds its address until it is accepted.
- R3: A descriptor whose buffer field (bits 4:0) is 16 or more, or whose buffer base is zero, causes no memory read and no register write.
- R4: The semantic field (bits 12:5) is compared with every table entry. Entry f sits at bits 8f+7:8f. The lowest matching index f selects destination register f+1. With no match the descriptor is skipped with no read and no write.
- R5: The format field (bits 14:13) set to 1, 2 or 3 fetches 2, 3 or 4 words, with exactly one memory read per word. Components that are not fetched read as zero.
- R6: When the swap bit (bit 15) is set, the byte order inside every fetched 32-bit word is reversed.
- R7: The 3-bit select for output component c sits at bits 18+3c:16+3c. Codes 0-3 copy fetched component 0-3, code 4 writes 0 and code 5 writes 0x3F800000. Output component c is wr_data bits 32c+31:32c, and attribute writes use mask 1111.
- R8: A format of 0, or any select above 5, on a descriptor that is not skipped raises the error output. That descriptor causes no read and no write. The error output stays high until the next start.
- R9: Exactly one single-cycle done pulse follows the last descriptor, including when the descriptor count is zero. When two descriptors hit the same register, the later one wins.
- R10: After reset there are no requests, no writes, no done and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a run when idle |
| vtx_index_i | input | 32 | Vertex index for the run |
| desc_count_i | input | 5 | Number of descriptors to process |
| desc_idx_o | output | 4 | Descriptor being looked up |
| desc_i | input | 28 | Descriptor at desc_idx_o |
| buf_sel_o | output | 4 | Buffer being looked up |
| buf_base_i | input | 32 | Base address of buffer buf_sel_o |
| buf_layout_i | input | 32 | Layout word of buffer buf_sel_o (stride in bits 26:11) |
| sem_table_i | input | 256 | 32 semantic entries of 8 bits |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | 32 | Read byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| wr_en_o | output | 1 | Register write strobe |
| wr_reg_o | output | 6 | Destination register 0..32 |
| wr_mask_o | output | 4 | Component write mask |
| wr_data_o | output | 128 | Four 32-bit components |
| done_o | output | 1 | End-of-list pulse |
| err_o | output | 1 | Unsupported format or select seen |

## Verification
A directed list is run twice, once with index 0 and once with index 7. Together the two runs separate the base term of the address from the index-times-stride term. The list covers a repeated semantic (first match wins), the last table entry (register 32), both skip causes, an unmatched semantic, both error causes and two descriptors writing one register.

An empty list shows that the index write and done work without any fetch. Random lists with random strides, swap bits and selects are then run. Each one is compared register by register with a bench model. The memory model's random ready stall separates correct request holding from dropped or repeated reads, which shows up in the read count.

// File: rtl/vaf_pkg.sv
package vaf_pkg;
    parameter int unsigned WORD_W    = 32;
    parameter int unsigned COMPS     = 4;
    parameter int unsigned SEM_W     = 8;
    parameter int unsigned BUF_IDX_W = 5;
    parameter int unsigned SEL_W     = 3;
    parameter logic [31:0] ONE_F     = 32'h3F80_0000;

    typedef enum logic [1:0] {
        FMT_BAD  = 2'd0,
        FMT_XY   = 2'd1,
        FMT_XYZ  = 2'd2,
        FMT_XYZW = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [COMPS-1:0][SEL_W-1:0] sel;
        logic                        swap;
        fmt_e                        fmt;
        logic [SEM_W-1:0]            sem;
        logic [BUF_IDX_W-1:0]        buf_id;
    } desc_t;

    localparam int unsigned DESC_W = $bits(desc_t);

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_INDEX = 3'd1,
        S_DESC  = 3'd2,
        S_REQ   = 3'd3,
        S_RSP   = 3'd4,
        S_WRITE = 3'd5,
        S_DONE  = 3'd6
    } state_e;
endpackage

// File: rtl/vaf_sem_match.sv
module vaf_sem_match #(
    parameter int unsigned NSEM  = 32,
    parameter int unsigned KEY_W = 8,
    localparam int unsigned IDX_W = $clog2(NSEM)
) (
    input  logic [NSEM*KEY_W-1:0] table_i,
    input  logic [KEY_W-1:0]      key_i,
    output logic                  hit_o,
    output logic [IDX_W-1:0]      idx_o
);
    logic [NSEM-1:0] match;

    generate
        for (genvar f = 0; f < NSEM; f++) begin : g_cmp
            assign match[f] = (table_i[f*KEY_W +: KEY_W] == key_i);
        end
    endgenerate

    // Scan from the top so the lowest matching entry is the one kept.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int f = NSEM - 1; f >= 0; f--) begin
            if (match[f]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(f);
            end
        end
    end

    always_comb begin
        if (hit_o) begin
            AST_HIT_ENTRY_EQUAL: assert (table_i[idx_o*KEY_W +: KEY_W] == key_i); // R4
        end
    end
endmodule

// File: rtl/vaf_addr_gen.sv
module vaf_addr_gen #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned IDX_W      = 32,
    parameter int unsigned LAYOUT_W   = 32,
    parameter int unsigned STRIDE_LSB = 11,
    parameter int unsigned STRIDE_W   = 16
) (
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [LAYOUT_W-1:0] layout_i,
    input  logic [IDX_W-1:0]    vidx_i,
    output logic [ADDR_W-1:0]   elem_addr_o
);
    localparam int unsigned STRIDE_MSB = STRIDE_LSB + STRIDE_W - 1;

    logic [STRIDE_W-1:0] stride;
    logic [ADDR_W-1:0]   offset;
    logic                unused_layout_bits;

    assign stride             = layout_i[STRIDE_MSB:STRIDE_LSB];
    assign unused_layout_bits = ^{layout_i[LAYOUT_W-1:STRIDE_MSB+1], layout_i[STRIDE_LSB-1:0]};
    assign offset             = ADDR_W'(vidx_i) * ADDR_W'(stride);
    assign elem_addr_o        = base_i + offset;
endmodule

// File: rtl/vaf_swizzle.sv
module vaf_swizzle
    import vaf_pkg::*;
(
    input  logic [COMPS-1:0][WORD_W-1:0] words_i,
    input  fmt_e                         fmt_i,
    input  logic                         swap_i,
    input  logic [COMPS-1:0][SEL_W-1:0]  sel_i,
    output logic [COMPS*WORD_W-1:0]      vec_o
);
    localparam int unsigned BYTES = WORD_W / 8;

    logic [COMPS-1:0][WORD_W-1:0] src;

    generate
        for (genvar c = 0; c < COMPS; c++) begin : g_src
            logic [WORD_W-1:0] rev;
            for (genvar b = 0; b < BYTES; b++) begin : g_byte
                assign rev[8*b +: 8] = words_i[c][8*(BYTES-1-b) +: 8];
            end
            // Components past the format's count are forced to zero.
            assign src[c] = (c <= int'(fmt_i)) ? (swap_i ? rev : words_i[c]) : '0;
        end

        for (genvar c = 0; c < COMPS; c++) begin : g_out
            logic [WORD_W-1:0] pick;
            always_comb begin
                case (sel_i[c])
                    3'd0, 3'd1, 3'd2, 3'd3: pick = src[sel_i[c][1:0]];
                    3'd5:                   pick = WORD_W'(ONE_F);
                    default:                pick = '0;
                endcase
            end
            assign vec_o[c*WORD_W +: WORD_W] = pick;
        end
    endgenerate
endmodule

// File: rtl/vtx_attr_fetch.sv
module vtx_attr_fetch
    import vaf_pkg::*;
#(
    parameter int unsigned MAX_DESC = 16,
    parameter int unsigned NSEM     = 32,
    parameter int unsigned NBUF     = 16,
    parameter int unsigned ADDR_W   = 32,
    localparam int unsigned DIDX_W  = $clog2(MAX_DESC),
    localparam int unsigned CNT_W   = $clog2(MAX_DESC + 1),
    localparam int unsigned BSEL_W  = $clog2(NBUF),
    localparam int unsigned REG_W   = $clog2(NSEM + 1),
    localparam int unsigned VEC_W   = COMPS * WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [WORD_W-1:0]     vtx_index_i,
    input  logic [CNT_W-1:0]      desc_count_i,
    output logic [DIDX_W-1:0]     desc_idx_o,
    input  logic [DESC_W-1:0]     desc_i,
    output logic [BSEL_W-1:0]     buf_sel_o,
    input  logic [ADDR_W-1:0]     buf_base_i,
    input  logic [WORD_W-1:0]     buf_layout_i,
    input  logic [NSEM*SEM_W-1:0] sem_table_i,
    output logic                  mem_req_valid_o,
    input  logic                  mem_req_ready_i,
    output logic [ADDR_W-1:0]     mem_req_addr_o,
    input  logic                  mem_rsp_valid_i,
    input  logic [WORD_W-1:0]     mem_rsp_data_i,
    output logic                  wr_en_o,
    output logic [REG_W-1:0]      wr_reg_o,
    output logic [COMPS-1:0]      wr_mask_o,
    output logic [VEC_W-1:0]      wr_data_o,
    output logic                  done_o,
    output logic                  err_o
);
    localparam int unsigned SIDX_W = $clog2(NSEM);

    typedef struct packed {
        state_e                       st;
        logic [CNT_W-1:0]             cnt;
        logic [DIDX_W-1:0]            di;
        logic [WORD_W-1:0]            vidx;
        logic [ADDR_W-1:0]            addr;
        logic [1:0]                   wcnt;
        fmt_e                         fmt;
        logic                         swap;
        logic [COMPS-1:0][SEL_W-1:0]  sel;
        logic [REG_W-1:0]             dst;
        logic [COMPS-1:0][WORD_W-1:0] words;
        logic                         err;
    } ctrl_t;

    ctrl_t q, d;

    desc_t             dsc;
    logic              sem_hit;
    logic [SIDX_W-1:0] sem_idx;
    logic [ADDR_W-1:0] elem_addr;
    logic [VEC_W-1:0]  fmt_vec;
    logic              buf_out_of_range;
    logic              skip_desc;
    logic              bad_desc;
    logic              last_desc;

    assign dsc = desc_t'(desc_i);

    vaf_sem_match #(
        .NSEM  (NSEM),
        .KEY_W (SEM_W)
    ) u_sem (
        .table_i (sem_table_i),
        .key_i   (dsc.sem),
        .hit_o   (sem_hit),
        .idx_o   (sem_idx)
    );

    vaf_addr_gen #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (WORD_W),
        .LAYOUT_W (WORD_W)
    ) u_addr (
        .base_i      (buf_base_i),
        .layout_i    (buf_layout_i),
        .vidx_i      (q.vidx),
        .elem_addr_o (elem_addr)
    );

    vaf_swizzle u_swz (
        .words_i (q.words),
        .fmt_i   (q.fmt),
        .swap_i  (q.swap),
        .sel_i   (q.sel),
        .vec_o   (fmt_vec)
    );

    assign buf_out_of_range = (dsc.buf_id >= BUF_IDX_W'(NBUF));
    assign skip_desc        = buf_out_of_range || (buf_base_i == '0) || !sem_hit;
    assign last_desc        = (CNT_W'(q.di) + CNT_W'(1)) >= q.cnt;

    always_comb begin
        bad_desc = (dsc.fmt == FMT_BAD);
        for (int c = 0; c < COMPS; c++) begin
            if (dsc.sel[c] > 3'd5) bad_desc = 1'b1;
        end
    end

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.st   = S_INDEX;
                    d.vidx = vtx_index_i;
                    d.cnt  = (desc_count_i > CNT_W'(MAX_DESC)) ? CNT_W'(MAX_DESC) : desc_count_i;
                    d.di   = '0;
                    d.err  = 1'b0;
                end
            end
            S_INDEX: begin
                d.st = (q.cnt == '0) ? S_DONE : S_DESC;
            end
            S_DESC: begin
                if (skip_desc || bad_desc) begin
                    if (!skip_desc) d.err = 1'b1;
                    if (last_desc) begin
                        d.st = S_DONE;
                    end else begin
                        d.di = q.di + DIDX_W'(1);
                        d.st = S_DESC;
                    end
                end else begin
                    d.st    = S_REQ;
                    d.addr  = elem_addr;
                    d.wcnt  = '0;
                    d.fmt   = dsc.fmt;
                    d.swap  = dsc.swap;
                    d.sel   = dsc.sel;
                    d.dst   = REG_W'(sem_idx) + REG_W'(1);
                    d.words = '0;
                end
            end
            S_REQ: begin
                if (mem_req_ready_i) d.st = S_RSP;
            end
            S_RSP: begin
                if (mem_rsp_valid_i) begin
                    d.words[q.wcnt] = mem_rsp_data_i;
                    if (q.wcnt == 2'(q.fmt)) begin
                        d.st = S_WRITE;
                    end else begin
                        d.wcnt = q.wcnt + 2'd1;
                        d.addr = q.addr + ADDR_W'(WORD_W / 8);
                        d.st   = S_REQ;
                    end
                end
            end
            S_WRITE: begin
                if (last_desc) begin
                    d.st = S_DONE;
                end else begin
                    d.di = q.di + DIDX_W'(1);
                    d.st = S_DESC;
                end
            end
            S_DONE: begin
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign desc_idx_o      = q.di;
    assign buf_sel_o       = dsc.buf_id[BSEL_W-1:0];
    assign mem_req_valid_o = (q.st == S_REQ);
    assign mem_req_addr_o  = q.addr;
    assign wr_en_o         = (q.st == S_INDEX) || (q.st == S_WRITE);
    assign wr_reg_o        = (q.st == S_INDEX) ? '0 : q.dst;
    assign wr_mask_o       = (q.st == S_INDEX) ? COMPS'(1) : '1;
    assign wr_data_o       = (q.st == S_INDEX) ? VEC_W'(q.vidx) : fmt_vec;
    assign done_o          = (q.st == S_DONE);
    assign err_o           = q.err;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid_o) && ($past(q.st) == S_RSP)
        |-> mem_req_addr_o == $past(mem_req_addr_o) + ADDR_W'(WORD_W / 8)); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o); // R5
    AST_INDEX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (q.st == S_IDLE) |=> wr_en_o && (wr_reg_o == '0)); // R1
    AST_REG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> wr_reg_o <= REG_W'(NSEM)); // R4
    AST_NO_WR_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !wr_en_o && !mem_req_valid_o); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
endmodule

// File: tb/tb_vtx_attr_fetch.sv
module tb_vtx_attr_fetch;
    localparam int MAX_DESC = 16;
    localparam int NSEM     = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  vtx_index_i = '0;
    logic [4:0]   desc_count_i = '0;
    logic [3:0]   desc_idx_o;
    logic [27:0]  desc_i;
    logic [3:0]   buf_sel_o;
    logic [31:0]  buf_base_i;
    logic [31:0]  buf_layout_i;
    logic [255:0] sem_table_i = '0;
    logic         mem_req_valid_o;
    logic         mem_req_ready_i = 1'b0;
    logic [31:0]  mem_req_addr_o;
    logic         mem_rsp_valid_i = 1'b0;
    logic [31:0]  mem_rsp_data_i = '0;
    logic         wr_en_o;
    logic [5:0]   wr_reg_o;
    logic [3:0]   wr_mask_o;
    logic [127:0] wr_data_o;
    logic         done_o;
    logic         err_o;

    logic [27:0]  desc_mem   [MAX_DESC];
    logic [31:0]  base_mem   [16];
    logic [31:0]  layout_mem [16];

    assign desc_i       = desc_mem[desc_idx_o];
    assign buf_base_i   = base_mem[buf_sel_o];
    assign buf_layout_i = layout_mem[buf_sel_o];

    always #4 clk = ~clk;

    vtx_attr_fetch dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .vtx_index_i (vtx_index_i),
        .desc_count_i (desc_count_i), .desc_idx_o (desc_idx_o), .desc_i (desc_i),
        .buf_sel_o (buf_sel_o), .buf_base_i (buf_base_i), .buf_layout_i (buf_layout_i),
        .sem_table_i (sem_table_i), .mem_req_valid_o (mem_req_valid_o),
        .mem_req_ready_i (mem_req_ready_i), .mem_req_addr_o (mem_req_addr_o),
        .mem_rsp_valid_i (mem_rsp_valid_i), .mem_rsp_data_i (mem_rsp_data_i),
        .wr_en_o (wr_en_o), .wr_reg_o (wr_reg_o), .wr_mask_o (wr_mask_o),
        .wr_data_o (wr_data_o), .done_o (done_o), .err_o (err_o)
    );

    int n_checks = 0;
    int n_errors = 0;

    logic [127:0] exp_reg [33];
    logic [127:0] act_reg [33];
    logic         exp_err;
    int           exp_reads, act_reads, act_done, act_writes;
    logic         pend = 1'b0;
    logic [31:0]  pend_addr = '0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h0100_0193) ^ 32'h9E37_79B9;
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [27:0] mk_desc(input int bid, input int sem, input int fmt,
                                            input int swp, input int s0, input int s1,
                                            input int s2, input int s3);
        return {3'(s3), 3'(s2), 3'(s1), 3'(s0), 1'(swp), 2'(fmt), 8'(sem), 5'(bid)};
    endfunction

    task automatic model_run(input int num, input logic [31:0] vidx);
        exp_err   = 1'b0;
        exp_reads = 0;
        exp_reg[0][31:0] = vidx;
        for (int i = 0; i < num; i++) begin
            logic [27:0]  dw;
            int           bid, sem, fmt, hit;
            logic [31:0]  w [4];
            logic [127:0] v;
            logic [31:0]  addr;
            dw  = desc_mem[i];
            bid = int'(dw[4:0]);
            sem = int'(dw[12:5]);
            fmt = int'(dw[14:13]);
            if (bid >= 16) continue;
            if (base_mem[bid] == 32'd0) continue;
            hit = -1;
            for (int f = NSEM - 1; f >= 0; f--)
                if (int'(sem_table_i[8*f +: 8]) == sem) hit = f;
            if (hit < 0) continue;
            if (fmt == 0 || dw[18:16] > 5 || dw[21:19] > 5 || dw[24:22] > 5 || dw[27:25] > 5) begin
                exp_err = 1'b1;
                continue;
            end
            addr = base_mem[bid] + vidx * {16'd0, layout_mem[bid][26:11]};
            for (int k = 0; k < 4; k++) begin
                w[k] = 32'd0;
                if (k <= fmt) begin
                    w[k] = mem_word(addr + 32'(4 * k));
                    if (dw[15]) w[k] = bswap(w[k]);
                    exp_reads++;
                end
            end
            for (int c = 0; c < 4; c++) begin
                logic [2:0] s;
                s = dw[16 + 3*c +: 3];
                v[32*c +: 32] = (s < 4) ? w[s[1:0]] : (s == 4) ? 32'd0 : 32'h3F80_0000;
            end
            exp_reg[hit + 1] = v;
        end
    endtask

    // Memory and register-file model, acting away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid_i = pend;
            if (pend) mem_rsp_data_i = mem_word(pend_addr);
            pend = 1'b0;
            if (wr_en_o) begin
                if (act_writes == 0)
                    chk("R1 first write reg/mask/index", {90'd0, wr_reg_o, wr_mask_o, wr_data_o[31:0]},
                        {90'd0, 6'd0, 4'b0001, vtx_index_i});
                act_writes++;
                for (int c = 0; c < 4; c++)
                    if (wr_mask_o[c]) act_reg[wr_reg_o][32*c +: 32] = wr_data_o[32*c +: 32];
            end
            if (done_o) act_done++;
            mem_req_ready_i = ($urandom % 4) != 0;
            if (mem_req_valid_o && mem_req_ready_i) begin
                pend      = 1'b1;
                pend_addr = mem_req_addr_o;
                act_reads++;
            end
        end
    end

    task automatic run(input int num, input logic [31:0] vidx, input string name);
        int cyc;
        model_run(num, vidx);
        act_reads  = 0;
        act_done   = 0;
        act_writes = 0;
        @(negedge clk);
        vtx_index_i  = vidx;
        desc_count_i = 5'(num);
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (act_done == 0 && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 5000) begin
            n_checks++;
            n_errors++;
            $display("FAIL R9 watchdog in %s: actual no done expected done", name);
        end
        repeat (3) @(negedge clk);
        chk({"R9 done pulse count ", name}, 128'(act_done), 128'd1);
        chk({"R8 error flag ", name}, 128'(err_o), 128'(exp_err));
        chk({"R3/R5 memory read count ", name}, 128'(act_reads), 128'(exp_reads));
        chk({"R1 register 0 ", name}, act_reg[0], exp_reg[0]);
        for (int r = 1; r < 33; r++)
            chk({"R4/R6/R7 register contents ", name}, act_reg[r], exp_reg[r]);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < 33; r++) begin
            exp_reg[r] = {4{32'hDEAD_0000 | 32'(r)}};
            act_reg[r] = exp_reg[r];
        end
        for (int b = 0; b < 16; b++) begin
            base_mem[b]   = 32'h0001_0000 * 32'(b + 1) + 32'h40;
            layout_mem[b] = 32'hA000_0123 | (32'(16 + 4*b) << 11);
        end
        base_mem[15] = 32'd0;
        for (int i = 0; i < MAX_DESC; i++) desc_mem[i] = '0;

        repeat (3) @(negedge clk);
        chk("R10 reset outputs", {124'd0, mem_req_valid_o, wr_en_o, done_o, err_o}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Empty list: only the index write and done.
        run(0, 32'd55, "empty");

        // Directed table: entry f = 100+f, entries 5 and 9 both 200.
        for (int f = 0; f < NSEM; f++) sem_table_i[8*f +: 8] = 8'(100 + f);
        sem_table_i[8*5 +: 8] = 8'd200;
        sem_table_i[8*9 +: 8] = 8'd200;
        desc_mem[0] = mk_desc(2, 200, 3, 1, 0, 1, 2, 3);   // first match -> reg 6, swap R6
        desc_mem[1] = mk_desc(3, 131, 1, 0, 0, 1, 4, 5);   // last entry -> reg 32, constants R7
        desc_mem[2] = mk_desc(20, 100, 3, 0, 0, 1, 2, 3);  // buffer out of range R3
        desc_mem[3] = mk_desc(15, 101, 3, 0, 0, 1, 2, 3);  // zero base R3
        desc_mem[4] = mk_desc(1, 77, 3, 0, 0, 1, 2, 3);    // no semantic match R4
        desc_mem[5] = mk_desc(1, 101, 0, 0, 0, 1, 2, 3);   // bad format R8
        desc_mem[6] = mk_desc(1, 102, 3, 0, 7, 1, 2, 3);   // bad select R8
        desc_mem[7] = mk_desc(4, 103, 2, 0, 0, 1, 2, 3);   // three words, w zero R5
        desc_mem[8] = mk_desc(5, 103, 1, 1, 0, 0, 1, 1);   // overwrites reg 4 R9
        run(9, 32'd0, "directed idx0");
        run(9, 32'd7, "directed idx7");
        run(8, 32'd3, "directed no overwrite");

        // Random lists.
        for (int t = 0; t < 30; t++) begin
            int num;
            for (int f = 0; f < NSEM; f++) sem_table_i[8*f +: 8] = 8'($urandom % 48);
            for (int b = 0; b < 16; b++) begin
                base_mem[b]   = ($urandom % 8 == 0) ? 32'd0 : $urandom;
                layout_mem[b] = ($urandom & 32'hF800_07FF) | (32'($urandom % 512) << 11);
            end
            num = 1 + int'($urandom % MAX_DESC);
            for (int i = 0; i < MAX_DESC; i++) begin
                int bid, fmt;
                int s [4];
                bid = ($urandom % 10 == 0) ? 16 + int'($urandom % 16) : int'($urandom % 16);
                fmt = ($urandom % 8 == 0) ? 0 : 1 + int'($urandom % 3);
                for (int c = 0; c < 4; c++)
                    s[c] = ($urandom % 20 == 0) ? 6 + int'($urandom % 2) : int'($urandom % 6);
                desc_mem[i] = mk_desc(bid, int'($urandom % 48), fmt, int'($urandom % 2),
                                      s[0], s[1], s[2], s[3]);
            end
            run(num, $urandom % 2000, "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule